// File: doc/BRIEF.md
# Pixel Serializer with Per-Byte Inversion

This block turns a sequence of fetched pattern bytes into the serial pixel stream of one video line. A byte is captured on a load strobe and then leaves the block one pixel per pixel-clock enable, most significant bit first. With the default 8-bit bytes, 32 loads make one 256-pixel line. The same datapath serves text mode, where the byte is a pattern-table row, and hires mode, where the byte is read straight from RAM during the processor's refresh cycle.

Each byte has a companion inversion flag, which is bit 7 of the code executed alongside it. The flag is latched on the same strobe as the byte. Every pixel of that byte is XORed with it, so a whole 8-pixel column appears either true or inverted. In hires mode only the codes $00 and $80 occur, so each of the 32 columns stays true or inverted over the full height of the picture.

A new load that arrives on the edge that consumes the last pixel takes over at once, so consecutive bytes join with no gap pixel. Sync and address generation belong to other blocks.

Top module: `vid_serializer`

## Requirements
- R1: While rst_ni is low, pixel_o and byte_done_o are 0.
- R2: After a clock edge with load_i high, pixel_o shows bit 7 (the MSB) of the loaded data_i. Each later edge with pix_en_i high and load_i low moves to the next lower bit, until all 8 bits are used.
- R3: On an edge with load_i low and pix_en_i low, the serializer state does not change, so pixel_o stays the same.
- R4: Every pixel equals its data bit XOR the inv_i value sampled by the same load. A change on inv_i with load_i low does not change pixel_o.
- R5: Once all 8 bits of a byte have been shifted, the block is empty. pixel_o then shows background 0 XOR the last latched flag, and pix_en_i has no effect until the next load.
- R6: byte_done_o is high for exactly one cycle, the cycle after the edge that consumed the 8th pixel of a byte (pix_en_i high with one bit remaining).
- R7: A load on the same edge that consumes the last pixel makes pixel_o show the new byte's MSB in the next cycle, with no gap pixel. byte_done_o still pulses.
- R8: A load in the middle of a byte discards the remaining bits and restarts from the new MSB. If load_i and pix_en_i are both high, the load takes priority.
- R9: data_i is ignored while load_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture data_i and inv_i |
| data_i | input | DATA_W | Pattern byte |
| inv_i | input | 1 | Inversion flag for the byte being loaded |
| pix_en_i | input | 1 | Pixel-clock enable; advances one pixel |
| pixel_o | output | 1 | Serial pixel after inversion |
| byte_done_o | output | 1 | One-cycle pulse after the last pixel of a byte |

## Verification
Faults in this block show up at pixel_o or byte_done_o within a few cycles.
- A wrong inversion latch flips all eight pixels of the affected byte.
- A shift-direction or shift-count fault misplaces the pixel shown in the first cycle after the first enable.
- A bit-counter fault either ends the byte early or late, which moves the byte_done_o pulse and the change to background, or makes a seamless load drop or repeat a pixel.

A reference model in the bench compares both outputs in every cycle. Random load and enable patterns are mixed with full seamless lines.

// File: rtl/vid_ser_pkg.sv
package vid_ser_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SHIFT = 2'd1,
    ACT_LOAD  = 2'd2
  } ser_act_e;

  // load wins over shift; shifting needs bits left
  function automatic ser_act_e decode_act(input logic load, input logic en, input logic busy);
    if (load)             return ACT_LOAD;
    else if (en && busy)  return ACT_SHIFT;
    else                  return ACT_HOLD;
  endfunction
endpackage

// File: rtl/vs_ctrl.sv
module vs_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 pix_en_i,
  output vid_ser_pkg::ser_act_e act_o,
  output logic                 busy_o,
  output logic                 done_o
);
  import vid_ser_pkg::*;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] left_q;
  logic             done_q;
  logic             last_bit;

  assign busy_o   = (left_q != '0);
  assign last_bit = (left_q == CNT_W'(1));
  assign act_o    = decode_act(load_i, pix_en_i, busy_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= pix_en_i && last_bit;
      unique case (act_o)
        ACT_LOAD:  left_q <= CNT_W'(DATA_W);
        ACT_SHIFT: left_q <= left_q - CNT_W'(1);
        default:   left_q <= left_q;
      endcase
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/vs_shifter.sv
module vs_shifter #(
  parameter int DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  vid_ser_pkg::ser_act_e act_i,
  input  logic [DATA_W-1:0]     data_i,
  output logic                  msb_o
);
  import vid_ser_pkg::*;
  logic [DATA_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sr_q <= '0;
    else if (act_i == ACT_LOAD)  sr_q <= data_i;
    else if (act_i == ACT_SHIFT) sr_q <= {sr_q[DATA_W-2:0], 1'b0};
  end

  assign msb_o = sr_q[DATA_W-1];
endmodule

// File: rtl/vs_inv_latch.sv
module vs_inv_latch (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  vid_ser_pkg::ser_act_e act_i,
  input  logic                  inv_i,
  output logic                  inv_o
);
  import vid_ser_pkg::*;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                inv_o <= 1'b0;
    else if (act_i == ACT_LOAD) inv_o <= inv_i;
  end
endmodule

// File: rtl/vid_serializer.sv
module vid_serializer #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              inv_i,
  input  logic              pix_en_i,
  output logic              pixel_o,
  output logic              byte_done_o
);
  import vid_ser_pkg::*;

  ser_act_e act;
  logic     busy, msb, inv_q;

  vs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .pix_en_i(pix_en_i),
    .act_o(act), .busy_o(busy), .done_o(byte_done_o)
  );

  vs_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .data_i(data_i), .msb_o(msb)
  );

  vs_inv_latch u_inv (
    .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .inv_i(inv_i), .inv_o(inv_q)
  );

  // empty register shows background 0 before the XOR
  assign pixel_o = (busy & msb) ^ inv_q;
endmodule

// File: rtl/vid_serializer_chk.sv
module vid_serializer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [DATA_W-1:0] data_i,
  input logic              inv_i,
  input logic              pix_en_i,
  input logic              pixel_o,
  input logic              byte_done_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!pixel_o && !byte_done_o);
    end
  end

  a_r2_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pixel_o == ($past(data_i[DATA_W-1]) ^ $past(inv_i)));

  a_r3_hold_no_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !pix_en_i) |=> $stable(pixel_o));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> !byte_done_o);

  a_r6_done_after_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> $past(pix_en_i));
endmodule

bind vid_serializer vid_serializer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .data_i(data_i),
  .inv_i(inv_i), .pix_en_i(pix_en_i), .pixel_o(pixel_o), .byte_done_o(byte_done_o)
);

// File: tb/vid_serializer_tb.sv
module vid_serializer_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] data_i = '0;
  logic       inv_i = 1'b0;
  logic       pix_en_i = 1'b0;
  logic       pixel_o, byte_done_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  logic [7:0] sr_m = '0;
  int         cnt_m = 0;
  logic       inv_m = 1'b0;
  logic       done_m = 1'b0;

  always #10 clk = ~clk;

  vid_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .data_i(data_i),
    .inv_i(inv_i), .pix_en_i(pix_en_i), .pixel_o(pixel_o), .byte_done_o(byte_done_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic exp_pixel();
    return ((cnt_m != 0) ? sr_m[7] : 1'b0) ^ inv_m;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input logic ld, input logic [7:0] d, input logic iv,
                      input logic en, input string tag);
    load_i = ld; data_i = d; inv_i = iv; pix_en_i = en;
    @(posedge clk);
    done_m = en && (cnt_m == 1);
    if (ld) begin
      sr_m = d; inv_m = iv; cnt_m = 8;
    end else if (en && cnt_m != 0) begin
      sr_m = sr_m << 1; cnt_m--;
    end
    @(negedge clk);
    check(tag, pixel_o, exp_pixel());
    check("R6", byte_done_o, done_m);
  endtask

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    check("R1", pixel_o, 1'b0);
    check("R1", byte_done_o, 1'b0);
    rst_ni = 1'b1;

    // R2: MSB first, one bit per enable, true video
    step(1'b1, 8'hA5, 1'b0, 1'b0, "R2");
    check("R2", pixel_o, 1'b1);
    for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 1'b0, 1'b1, "R2");
    // R5: empty shows background; enables do nothing
    check("R5", pixel_o, 1'b0);
    step(1'b0, 8'hFF, 1'b0, 1'b1, "R5");

    // R4: inverted byte, inv_i toggled without load is ignored
    step(1'b1, 8'hF0, 1'b1, 1'b0, "R4");
    check("R4", pixel_o, 1'b0);
    step(1'b0, 8'h0F, 1'b0, 1'b0, "R4");
    check("R4", pixel_o, 1'b0);
    // R3 and R9: hold with changing data
    for (int i = 0; i < 4; i++) step(1'b0, 8'($urandom), 1'($urandom), 1'b0, "R9");
    for (int i = 0; i < 8; i++) step(1'b0, 8'($urandom), 1'b0, 1'b1, "R4");
    check("R5", pixel_o, 1'b1);

    // R8: mid-byte reload with simultaneous enable
    step(1'b1, 8'hFF, 1'b0, 1'b0, "R8");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R8");
    step(1'b1, 8'h00, 1'b0, 1'b1, "R8");
    check("R8", pixel_o, 1'b0);

    // R7: full line of 32 seamless bytes, $00/$80 style column flags
    for (int b = 0; b < 32; b++) begin
      logic [7:0] d = 8'($urandom);
      step(1'b1, d, 1'(b % 3 == 0), (b != 0), "R7");
      check("R7", pixel_o, d[7] ^ 1'(b % 3 == 0));
      for (int i = 0; i < 7; i++) step(1'b0, 8'($urandom), 1'($urandom), 1'b1, "R7");
    end
    step(1'b0, 8'h00, 1'b0, 1'b1, "R6");
    step(1'b0, 8'h00, 1'b0, 1'b1, "R5");

    // random mix
    for (int i = 0; i < 3000; i++)
      step(($urandom % 6) == 0, 8'($urandom), 1'($urandom), ($urandom % 4) != 0, "R3,R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule